// File: doc/BRIEF.md
# System management interrupt arbiter

This block collects management events into a small status register and drives one active-low interrupt line toward the processor. A control register holds a global enable, a firmware-release enable, a legacy-USB enable and an end-of-interrupt (EOI) handshake bit. The line is asserted when the global enable is on and any status bit is set together with its enable. Status bits at index 2 and above carry no enable of their own, because their sources are already gated upstream.

The first assertion after reset needs no handshake. After that, the line stays low until software writes 1 to the EOI bit. The arbiter then forces the line high for a fixed gap of `GAP_CYC` clocks. If anything is still pending when the gap ends, the line is asserted again; otherwise it waits for the next pending event. EOI is cleared by hardware at every assertion.

Software reaches the registers through a single-cycle write port. Address 0 is the control register, address 1 is the status register, whose bits clear when written with 1, and address 2 is the release command. A lock input freezes the global enable.

Top module: `mgmt_irq_arbiter`

## Requirements
- R1: `smi_n` goes low only when the global enable (control bit 0) is 1 and at least one status bit is 1 with its enable. Status bit 0 is enabled by control bit 1 (firmware) and status bit 1 by control bit 2 (legacy USB).
- R2: After reset, the first pending condition drives `smi_n` low on the clock edge after the status bit becomes visible, without any EOI write.
- R3: At every assertion of `smi_n`, the EOI bit (control bit 3) reads 0 from that edge on, even if it was 1 before.
- R4: Once low, `smi_n` stays low for as long as EOI is 0, whatever happens to the status and enables.
- R5: On the edge after EOI reads 1 while the line is low, `smi_n` goes high for exactly `GAP_CYC` (default 4) cycles. It then goes low again if anything is pending; otherwise it stays high until a pending condition appears.
- R6: Writing address 2 with data bit 0 = 1 sets status bit 0 on that edge.
- R7: An enable that turns on while its status bit is already 1 causes an assertion on the next edge, if the arbiter is armed.
- R8: While `lock` is 1, control writes leave the global enable unchanged; the other control bits still update.
- R9: Reset (synchronous, active low) gives `smi_n` = 1, `ctrl_q` = 0 and `sts_q` = 0.
- R10: Writing address 1 clears each status bit whose data bit is 1 and leaves the rest. An `evt` pulse on the same bit in the same cycle wins, so the bit stays 1.
- R11: Status bits 2 to `SRC_W-1` need no enable bit; with the global enable on, each of them alone causes an assertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | 0 control, 1 status (write 1 to clear), 2 release command |
| wr_data | input | SRC_W | Write data; control uses bits 3:0 |
| lock | input | 1 | Freezes the global enable against writes |
| evt | input | SRC_W | Single-cycle event pulses that set status bits |
| smi_n | output | 1 | Active-low interrupt line |
| ctrl_q | output | 4 | Control register: {EOI, USB en, firmware en, global en} |
| sts_q | output | SRC_W | Status register |

## Verification
Register results are due one edge after the write or event, and the line responds one edge later again. The bench drives every input at a falling edge and samples at the next falling edge, so each check sits a known whole number of edges after its stimulus. The gap is measured by sampling `smi_n` at each falling edge after the EOI write: low on the first sample, then high on exactly four samples, then low again. The enable sweep covers all eight combinations of the three enables against a single event on every status bit.

// File: rtl/mgmt_irq_pkg.sv
// Shared encodings for the management interrupt arbiter.
// Assumes: control register is 4 bits; the status width is set by the top.
package mgmt_irq_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STS  = 2'd1;
    localparam logic [1:0] ADDR_REL  = 2'd2;

    localparam int CTRL_W = 4;
    localparam int CB_GLB = 0;
    localparam int CB_FW  = 1;
    localparam int CB_USB = 2;
    localparam int CB_EOI = 3;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } arb_state_t;
endpackage

// File: rtl/mgmt_irq_ctrl.sv
// Control register: global enable, firmware enable, USB enable, EOI.
// Assumes: wr_ctrl is a one-cycle strobe. An assertion (fire) clears EOI
// and takes priority over a simultaneous software write of EOI.
module mgmt_irq_ctrl
    import mgmt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              lock,
    input  logic              fire,
    output logic [CTRL_W-1:0] ctrl_q
);
    // Register update: the lock guards only the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                if (!lock) ctrl_q[CB_GLB] <= wr_data[CB_GLB];
                ctrl_q[CB_FW]  <= wr_data[CB_FW];
                ctrl_q[CB_USB] <= wr_data[CB_USB];
                ctrl_q[CB_EOI] <= wr_data[CB_EOI];
            end
            if (fire) ctrl_q[CB_EOI] <= 1'b0;
        end
    end

    AST_LOCK_GLB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && lock) |=> $stable(ctrl_q[CB_GLB])); // R8
endmodule

// File: rtl/mgmt_irq_status.sv
// Status register: bits are set by event pulses and cleared by writing 1.
// Assumes: set_vec and clr_vec are single-cycle; a set beats a clear.
module mgmt_irq_status #(
    parameter int SRC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_vec,
    input  logic [SRC_W-1:0] clr_vec,
    output logic [SRC_W-1:0] sts_q
);
    // Status update: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_vec) | set_vec;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((sts_q & $past(set_vec)) == $past(set_vec))); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((sts_q & $past(clr_vec & ~set_vec)) == '0)); // R10
endmodule

// File: rtl/mgmt_irq_fsm.sv
// Arbitration state machine for the active-low interrupt line.
// ARMED: line high, fire as soon as something is pending.
// ACTIVE: line low until EOI is 1. GAP: line forced high for GAP_CYC clocks.
// Assumes: GAP_CYC >= 2; eoi is cleared by the control block on fire.
module mgmt_irq_fsm
    import mgmt_irq_pkg::*;
#(
    parameter int GAP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic eoi,
    output logic fire,
    output logic smi_n
);
    localparam int CW = $clog2(GAP_CYC);
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);
    localparam int RW = $clog2(GAP_CYC + 1) + 1;
    localparam logic [RW-1:0] RUN_MAX = '1;

    arb_state_t state, nxt;
    logic [CW-1:0] cnt;
    logic gap_done;

    // Gap end detection.
    always_comb gap_done = (state == ST_GAP) && (cnt == GAP_LAST);

    // Next-state selection and fire strobe.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_ARMED:  if (pend) nxt = ST_ACTIVE;
            ST_ACTIVE: if (eoi)  nxt = ST_GAP;
            ST_GAP:    if (gap_done) nxt = pend ? ST_ACTIVE : ST_ARMED;
            default:   nxt = ST_ARMED;
        endcase
        fire = (nxt == ST_ACTIVE) && (state != ST_ACTIVE);
    end

    // State, gap counter and registered line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ARMED;
            cnt   <= '0;
            smi_n <= 1'b1;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_GAP && !gap_done) ? cnt + 1'b1 : '0;
            smi_n <= (nxt != ST_ACTIVE);
        end
    end

    // Checker bookkeeping: length of the current high run, and whether the line has ever fired.
    logic [RW-1:0] chk_hi_run;
    logic          chk_had_fire;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_hi_run   <= '0;
            chk_had_fire <= 1'b0;
        end else begin
            chk_hi_run   <= !smi_n ? '0 : (chk_hi_run == RUN_MAX ? RUN_MAX : chk_hi_run + 1'b1);
            chk_had_fire <= chk_had_fire | !smi_n;
        end
    end

    AST_FIRE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_n) |-> $past(pend)); // R1
    AST_EOI_CLEAR_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_n) |-> !eoi); // R3
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!smi_n && !eoi) |=> !smi_n); // R4
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(smi_n) && chk_had_fire) |-> (chk_hi_run >= RW'(GAP_CYC))); // R5
endmodule

// File: rtl/mgmt_irq_arbiter.sv
// Top level: write decode, enable masking and instance wiring.
// Assumes: SRC_W >= 4. Status bit 0 is the firmware source, bit 1 the
// legacy USB source, higher bits are pre-gated and always enabled.
module mgmt_irq_arbiter
    import mgmt_irq_pkg::*;
#(
    parameter int SRC_W   = 6,
    parameter int GAP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [SRC_W-1:0]  wr_data,
    input  logic              lock,
    input  logic [SRC_W-1:0]  evt,
    output logic              smi_n,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [SRC_W-1:0]  sts_q
);
    logic             wr_ctrl, wr_sts, wr_rel;
    logic [SRC_W-1:0] set_vec, clr_vec, en_mask;
    logic             pend, fire;

    // Write decode.
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_sts  = wr_en && (wr_addr == ADDR_STS);
        wr_rel  = wr_en && (wr_addr == ADDR_REL);
        clr_vec = wr_sts ? wr_data : '0;
        set_vec = evt | {{(SRC_W-1){1'b0}}, wr_rel & wr_data[0]};
    end

    // Per-bit enable selection.
    for (genvar i = 0; i < SRC_W; i++) begin : g_mask
        if (i == 0) begin : g_fw
            assign en_mask[i] = ctrl_q[CB_FW];
        end else if (i == 1) begin : g_usb
            assign en_mask[i] = ctrl_q[CB_USB];
        end else begin : g_free
            assign en_mask[i] = 1'b1;
        end
    end

    // Pending condition seen by the arbiter.
    always_comb pend = ctrl_q[CB_GLB] && |(sts_q & en_mask);

    mgmt_irq_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data[CTRL_W-1:0]),
        .lock    (lock),
        .fire    (fire),
        .ctrl_q  (ctrl_q)
    );

    mgmt_irq_status #(.SRC_W(SRC_W)) i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .sts_q   (sts_q)
    );

    mgmt_irq_fsm #(.GAP_CYC(GAP_CYC)) i_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .eoi   (ctrl_q[CB_EOI]),
        .fire  (fire),
        .smi_n (smi_n)
    );

    AST_RELEASE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel && wr_data[0]) |=> sts_q[0]); // R6
endmodule

// File: tb/test_mgmt_irq_arbiter.sv
module test_mgmt_irq_arbiter;
    localparam int SRC_W = 6;
    localparam int GAP   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [SRC_W-1:0] wr_data = '0;
    logic             lock = 1'b0;
    logic [SRC_W-1:0] evt = '0;
    logic             smi_n;
    logic [3:0]       ctrl_q;
    logic [SRC_W-1:0] sts_q;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mgmt_irq_arbiter #(.SRC_W(SRC_W), .GAP_CYC(GAP)) i_mgmt_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lock(lock), .evt(evt), .smi_n(smi_n),
        .ctrl_q(ctrl_q), .sts_q(sts_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; evt = '0; lock = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [SRC_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input int i);
        evt = SRC_W'(1) << i;
        step();
        evt = '0;
    endtask

    initial begin
        do_reset();
        // R9 reset values
        chk("R9 smi_n", 32'(smi_n), 1);
        chk("R9 ctrl", 32'(ctrl_q), 0);
        chk("R9 sts", 32'(sts_q), 0);

        // R1 / R11 sweep: every enable combination against every source
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int i = 0; i < SRC_W; i++) begin
                logic exp_fire;
                do_reset();
                wr(2'd0, SRC_W'(cfg));
                pulse(i);
                step();
                exp_fire = cfg[0] && ((i == 0) ? cfg[1] : (i == 1) ? cfg[2] : 1'b1);
                chk((i >= 2) ? "R11 free source" : "R1 enabled source", 32'(smi_n), 32'(!exp_fire));
            end
        end

        // R2 first assertion, R3 EOI auto-clear
        do_reset();
        wr(2'd0, 6'h0D);
        chk("R3 eoi set by write", 32'(ctrl_q[3]), 1);
        pulse(1);
        chk("R2 not yet low", 32'(smi_n), 1);
        step();
        chk("R2 first fire", 32'(smi_n), 0);
        chk("R3 eoi cleared on fire", 32'(ctrl_q[3]), 0);

        // R4 holds low with status cleared and no EOI
        wr(2'd1, '1);
        chk("R10 clear all", 32'(sts_q), 0);
        step(); step(); step();
        chk("R4 held low", 32'(smi_n), 0);
        pulse(2);

        // R5 gap with pending source
        wr(2'd0, 6'h0D);
        chk("R4 low until edge after eoi", 32'(smi_n), 0);
        step();
        chk("R5 gap cycle 1", 32'(smi_n), 1);
        for (int k = 2; k <= GAP; k++) begin
            step();
            chk("R5 gap cycle", 32'(smi_n), 1);
        end
        step();
        chk("R5 refire after gap", 32'(smi_n), 0);
        chk("R3 eoi cleared on refire", 32'(ctrl_q[3]), 0);

        // R5 no pending: stays high
        wr(2'd1, '1);
        wr(2'd0, 6'h0D);
        step();
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R5 idle high", 32'(smi_n), 1);
        end
        pulse(1);
        step();
        chk("R1 armed fire", 32'(smi_n), 0);

        // R6 release sets firmware status, R7 enable rising with pending status
        do_reset();
        wr(2'd0, 6'h01);
        wr(2'd2, 6'h01);
        chk("R6 release sets bit0", 32'(sts_q), 1);
        step(); step();
        chk("R7 no fire while disabled", 32'(smi_n), 1);
        wr(2'd0, 6'h03);
        chk("R7 one edge after enable", 32'(smi_n), 1);
        step();
        chk("R7 fire on enable", 32'(smi_n), 0);

        do_reset();
        wr(2'd0, 6'h03);
        wr(2'd2, 6'h01);
        step();
        chk("R6 release fires", 32'(smi_n), 0);

        // R8 lock
        do_reset();
        lock = 1'b1;
        wr(2'd0, 6'h07);
        chk("R8 glb frozen low", 32'(ctrl_q), 32'h6);
        pulse(1);
        step();
        chk("R8 no fire when frozen", 32'(smi_n), 1);
        lock = 1'b0;
        wr(2'd0, 6'h07);
        chk("R8 glb written unlocked", 32'(ctrl_q), 32'h7);
        step();
        chk("R7 fire after unlock", 32'(smi_n), 0);
        lock = 1'b1;
        wr(2'd0, 6'h00);
        chk("R8 glb frozen high", 32'(ctrl_q), 32'h1);
        lock = 1'b0;

        // R10 write-one-to-clear and set priority
        do_reset();
        pulse(2); pulse(3);
        chk("R10 set", 32'(sts_q), 32'h0C);
        wr(2'd1, 6'h04);
        chk("R10 clear one", 32'(sts_q), 32'h08);
        wr(2'd1, 6'h00);
        chk("R10 zero write", 32'(sts_q), 32'h08);
        evt = 6'h08;
        wr(2'd1, 6'h08);
        evt = '0;
        chk("R10 set wins", 32'(sts_q), 32'h08);
        chk("R1 no fire with glb off", 32'(smi_n), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule